// File: doc/BRIEF.md
# Sampled Three-State Phase/Frequency Detector with Delayed Reset

This block compares a reference clock with a divided feedback clock and drives two correction pulses, UP and DOWN, that a charge pump would integrate. Both input clocks are brought into a faster sampling clock domain. There, a rising edge on either input sets a flag. Once both flags are set, a common clear removes them. The width of the lone UP (or DOWN) pulse therefore measures how far one input leads the other, in sampling-clock cycles.

The common clear is held off by a programmable number of sampling cycles. As a result, both outputs pulse together for a short, defined time even when the inputs are exactly aligned. This removes the dead zone in which a small phase error would produce no correction at all. A faster input wins more often than it loses, so the detector also steers toward equal frequency. Edges that arrive while their own flag is already set, and edges that arrive during the clear hold-off, are dropped. This keeps the detector in its three meaningful conditions: idle, UP pending and DOWN pending. The short both-high clear interval is the only other condition it passes through.

Top module: `pfd_tri_state`

## Requirements
- R1: While `rst_n` is low, `up_o` and `dn_o` are both low. After release the detector is idle.
- R2: A rising edge on `ref_in` while neither output is high sets `up_o`. `up_o` stays high until a rising edge on `fb_in` has been seen. If the feedback edge arrives L sampling cycles after the reference edge, `up_o` is high for L + D + 1 cycles, where D is the delay setting.
- R3: The mirror of R2 holds with the inputs swapped. A feedback edge leading by L cycles gives `dn_o` high for L + D + 1 cycles.
- R4: Rising edges on both inputs in the same sampling cycle raise `up_o` and `dn_o` together, in the same cycle, for exactly D + 1 cycles. There is no dead zone at zero phase error.
- R5: Once the second flag is set, both outputs stay high together for exactly D + 1 sampling cycles and then fall in the same cycle. D is the unsigned value of the 4-bit `dly_sel`, taken in the cycle the second flag is set (0 gives 1 cycle, 15 gives 16 cycles).
- R6: A rising edge on an input whose flag is already set is ignored. It neither lengthens nor restarts the pulse, and it gives no second pulse.
- R7: Rising edges on either input during the both-high clear interval are ignored. After the clear the detector is idle, and no output rises until a new edge arrives.
- R8: When the reference frequency is higher than the feedback frequency, the total `up_o` high time over a long window exceeds the total `dn_o` high time. When the feedback frequency is higher, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| fb_in | input | 1 | Divided feedback clock, asynchronous to `clk` |
| dly_sel | input | DLY_W (4) | Clear hold-off D in sampling cycles; both outputs stay high D + 1 cycles |
| up_o | output | 1 | Pump-up pulse: the reference leads |
| dn_o | output | 1 | Pump-down pulse: the feedback leads |

## Verification
Single reference/feedback edge pairs are swept over offsets from six cycles of feedback lag to six cycles of feedback lead. The sweep is repeated at the shortest, a middle and the longest clear hold-off. Each pair tells apart which output rises first, the width of the leading pulse (offset + D + 1) and the width of the trailing one (D + 1). The zero-offset pairs confirm that the dead zone is gone. Extra reference edges placed inside a pending UP pulse, and inside the clear interval, separate a detector that ignores them from one that re-arms. Two long runs with unequal input periods show which output dominates in the frequency-acquisition case.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   // Bit 0 drives the pump-up output, bit 1 the pump-down output.
   typedef enum logic [1:0] {
      PFD_IDLE = 2'b00,
      PFD_LEAD = 2'b01,
      PFD_LAG  = 2'b10,
      PFD_CLR  = 2'b11
   } pfd_state_e;

   localparam int unsigned PFD_CH_REF = 0;
   localparam int unsigned PFD_CH_FB  = 1;
   localparam int unsigned PFD_NUM_CH = 2;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   // STAGES synchroniser flops plus one history flop
   localparam int unsigned LAST = STAGES;

   logic [LAST:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else begin
         shreg <= {shreg[LAST-1:0], async_in};
      end
   end

   assign rise_o = shreg[LAST-1] & ~shreg[LAST];
endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             expired
);
   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
   import pfd_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_rise,
   input  logic             fb_rise,
   input  logic [DLY_W-1:0] dly_sel,
   output logic             up_o,
   output logic             dn_o
);
   pfd_state_e state_q, state_d;
   logic       arm_clear;
   logic       clear_done;

   always_comb begin
      state_d   = state_q;
      arm_clear = 1'b0;
      unique case (state_q)
         PFD_IDLE: begin
            if (ref_rise && fb_rise) begin
               state_d   = PFD_CLR;
               arm_clear = 1'b1;
            end else if (ref_rise) begin
               state_d = PFD_LEAD;
            end else if (fb_rise) begin
               state_d = PFD_LAG;
            end
         end
         PFD_LEAD: begin
            if (fb_rise) begin
               state_d   = PFD_CLR;
               arm_clear = 1'b1;
            end
         end
         PFD_LAG: begin
            if (ref_rise) begin
               state_d   = PFD_CLR;
               arm_clear = 1'b1;
            end
         end
         PFD_CLR: begin
            if (clear_done) begin
               state_d = PFD_IDLE;
            end
         end
         default: state_d = PFD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PFD_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   pfd_clear_timer #(
      .DLY_W (DLY_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (arm_clear),
      .load_val (dly_sel),
      .expired  (clear_done)
   );

   assign up_o = state_q[0];
   assign dn_o = state_q[1];
endmodule

// File: rtl/pfd_tri_state.sv
module pfd_tri_state
   import pfd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DLY_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [DLY_W-1:0] dly_sel,
   output logic             up_o,
   output logic             dn_o
);
   initial begin : p_param_chk
      if (SYNC_STAGES < 2) $error("pfd_tri_state: SYNC_STAGES must be at least 2");
      if (DLY_W < 1 || DLY_W > 8) $error("pfd_tri_state: DLY_W must lie in 1..8");
   end

   logic [PFD_NUM_CH-1:0] raw_in;
   logic [PFD_NUM_CH-1:0] rise;

   assign raw_in[PFD_CH_REF] = ref_in;
   assign raw_in[PFD_CH_FB]  = fb_in;

   for (genvar ch = 0; ch < PFD_NUM_CH; ch++) begin : g_sync
      pfd_edge_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (raw_in[ch]),
         .rise_o   (rise[ch])
      );
   end

   pfd_flag_core #(
      .DLY_W (DLY_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_rise (rise[PFD_CH_REF]),
      .fb_rise  (rise[PFD_CH_FB]),
      .dly_sel  (dly_sel),
      .up_o     (up_o),
      .dn_o     (dn_o)
   );
endmodule

// File: rtl/pfd_tri_state_chk.sv
module pfd_tri_state_chk #(
   parameter int unsigned DLY_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DLY_W-1:0] dly_sel,
   input logic             up_o,
   input logic             dn_o
);
   localparam int unsigned RUN_W = DLY_W + 1;

   logic             both;
   logic             both_prev;
   logic [DLY_W-1:0] dly_prev;
   logic [DLY_W-1:0] dly_cap;
   logic [RUN_W-1:0] both_run;

   assign both = up_o & dn_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_prev <= 1'b0;
         dly_prev  <= '0;
         dly_cap   <= '0;
         both_run  <= '0;
      end else begin
         both_prev <= both;
         dly_prev  <= dly_sel;
         if (both && !both_prev) dly_cap <= dly_prev;
         if (both) both_run <= both_run + 1'b1;
         else      both_run <= '0;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!up_o && !dn_o)); // R1

   AST_UP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o && !dn_o) |=> up_o); // R2

   AST_DN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_o && !up_o) |=> dn_o); // R3

   AST_JOINT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up_o) |-> ($past(dn_o) && !dn_o)); // R5

   AST_CLEAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((both_run != '0) && !both) |-> (both_run == RUN_W'(dly_cap) + 1'b1)); // R5

   AST_CLEAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      both_run <= RUN_W'(1 << DLY_W)); // R7
endmodule

bind pfd_tri_state pfd_tri_state_chk #(.DLY_W(DLY_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dly_sel (dly_sel),
   .up_o    (up_o),
   .dn_o    (dn_o)
);

// File: tb/sim_pfd_tri_state.sv
module sim_pfd_tri_state;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic [3:0] dly_sel = 4'd0;
   logic       up_o;
   logic       dn_o;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;

   always #5 clk = ~clk;

   pfd_tri_state #(.SYNC_STAGES(2), .DLY_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .dly_sel(dly_sel), .up_o(up_o), .dn_o(dn_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   function automatic bit pulse(input int t, input int s);
      return (s >= 0) && (t >= s) && (t < s + 3);
   endfunction

   // ref edge at ra (second at ra2 if >= 0), feedback edge at rb, hold-off d
   task automatic trial(input string req, input int ra, input int ra2, input int rb, input int d);
      int up_cnt = 0, dn_cnt = 0, up_first = -1, dn_first = -1;
      int up_rises = 0, dn_rises = 0;
      bit up_last = 1'b0, dn_last = 1'b0;
      int lead;
      int exp_up, exp_dn, exp_order, act_order;
      dly_sel = 4'(d);
      for (int t = 0; t < 80; t++) begin
         @(negedge clk);
         if (up_o) begin
            up_cnt++;
            if (up_first < 0) up_first = t;
            if (!up_last) up_rises++;
         end
         if (dn_o) begin
            dn_cnt++;
            if (dn_first < 0) dn_first = t;
            if (!dn_last) dn_rises++;
         end
         up_last = up_o;
         dn_last = dn_o;
         ref_in = pulse(t, ra) | pulse(t, ra2);
         fb_in  = pulse(t, rb);
      end
      lead = rb - ra;
      exp_up = (lead > 0) ? lead + d + 1 : d + 1;
      exp_dn = (lead < 0) ? -lead + d + 1 : d + 1;
      exp_order = (lead > 0) ? 1 : ((lead < 0) ? -1 : 0);
      act_order = (up_first < 0 || dn_first < 0) ? 9 :
                  ((up_first < dn_first) ? 1 : ((up_first > dn_first) ? -1 : 0));
      check(req, $sformatf("up width lead=%0d d=%0d", lead, d), up_cnt, exp_up);
      check(req, $sformatf("dn width lead=%0d d=%0d", lead, d), dn_cnt, exp_dn);
      check(req, $sformatf("first-rise order lead=%0d d=%0d", lead, d), act_order, exp_order);
      if (ra2 >= 0) begin
         check(req, "up pulse count", up_rises, 1);
         check(req, "dn pulse count", dn_rises, 1);
      end
   endtask

   task automatic freq_run(input string req, input int pref, input int pfb, input bit expect_up);
      int up_tot = 0, dn_tot = 0;
      dly_sel = 4'd2;
      for (int t = 0; t < 900; t++) begin
         @(negedge clk);
         if (up_o) up_tot++;
         if (dn_o) dn_tot++;
         ref_in = (t % pref) < 3;
         fb_in  = ((t + 5) % pfb) < 3;
      end
      check(req, $sformatf("dominant output (up=%0d dn=%0d)", up_tot, dn_tot),
            int'(up_tot > dn_tot), int'(expect_up));
   endtask

   initial begin : p_main
      int dset[3] = '{0, 5, 15};
      // R1: outputs quiet in reset
      repeat (4) @(negedge clk);
      check("R1", "up in reset", int'(up_o), 0);
      check("R1", "dn in reset", int'(dn_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1", "up after release", int'(up_o), 0);
      check("R1", "dn after release", int'(dn_o), 0);

      // R2 / R3 / R4 / R5: offset sweep at three hold-off settings
      foreach (dset[i]) begin
         for (int off = -6; off <= 6; off++) begin
            if (off > 0)      trial("R2", 10, -1, 10 + off, dset[i]);
            else if (off < 0) trial("R3", 10 - off, -1, 10, dset[i]);
            else              trial("R4", 10, -1, 10, dset[i]);
         end
      end
      trial("R5", 10, -1, 10, 7);

      // R6: second reference edge while UP is pending
      trial("R6", 10, 16, 25, 3);
      // R7: reference edge inside the clear interval
      trial("R7", 10, 17, 12, 15);

      // R8: frequency offset, both directions
      freq_run("R8", 20, 23, 1'b1);
      rst_n = 1'b0;
      ref_in = 1'b0;
      fb_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      freq_run("R8", 23, 20, 1'b0);

      summary();
      $finish;
   end

   initial begin : p_watchdog
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end
endmodule